// File: doc/BRIEF.md
# Folded FIR Address and Enable Sequencer

This block is the control unit for a time-multiplexed, coefficient-symmetric FIR filter. The filter folds FOLD taps onto each multiplier, so one input sample is processed over FOLD clock cycles. Each accepted input sample starts a sequence. During the sequence the block drives two read addresses. The forward address serves the forward delay line and the coefficient table. The reverse address serves the delay line that carries samples back toward the start of the chain.

Along with the addresses, the block sets the timing of the write and capture strobes for the delay lines. It also produces an output-valid flag that lines up with the filter result. The datapath is not part of this block. The datapath reads the addresses, the strobes and a constant mode flag. The mode flag tells the datapath which end of the reverse delay line its capture registers should sample.

Two parameters set the variant. FOLD is the overclocking factor. ODD_ORDER selects an odd filter order; when it is set, the last stage of the chain has no capture register.

Top module: `fir_fold_seq`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) sets fwd_addr to 0 and rev_addr to FOLD-1. It also clears shift_we, cap_en, last_cap_en and out_valid. A sample that was in flight before the reset never shows up on out_valid.
- R2: If in_valid is high at a rising edge, fwd_addr reads 0 after that edge. It then rises by one at each following edge up to FOLD-1. At the next edge it returns to 0 and stays there until the next sample.
- R3: rev_addr always equals FOLD-1 minus fwd_addr. It counts down from FOLD-1 to 0 on the same edges that fwd_addr counts up.
- R4: If in_valid is high while a sequence is running, both addresses restart from their start values: fwd_addr goes to 0 and rev_addr goes to FOLD-1 after that edge.
- R5: shift_we is high for exactly the one cycle after each edge at which in_valid was high. This is the cycle in which fwd_addr is 0.
- R6: cap_en is in_valid delayed by 3 clocks when FOLD is 4 or more, by 1 clock when FOLD is 3, and by 0 clocks when FOLD is 2. With a delay of 0 it follows in_valid combinationally.
- R7: For an even order, last_cap_en leads cap_en by one clock. When FOLD is 2 there is no earlier slot, so it matches cap_en. For an odd order (ODD_ORDER=1), last_cap_en is held at 0.
- R8: cap_from_input is 1 when FOLD is 2, meaning the capture registers take the reverse line's input. It is 0 for any other FOLD, meaning they take the reverse line's output.
- R9: out_valid is in_valid delayed by FOLD-1+5 clocks.
- R10: Samples on consecutive cycles each give their own pulse on shift_we, cap_en, last_cap_en and out_valid, with no pulse merged or lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Accepted input sample strobe |
| fwd_addr | output | $clog2(FOLD) | Up-counting address for the forward line and coefficient table |
| rev_addr | output | $clog2(FOLD) | Down-counting address for the reverse line |
| shift_we | output | 1 | Write enable for the forward delay line |
| cap_en | output | 1 | Capture enable for the reverse-line capture registers |
| last_cap_en | output | 1 | Capture enable for the last stage (even order only) |
| cap_from_input | output | 1 | Mode: the capture registers sample the reverse line's input |
| out_valid | output | 1 | Filter output valid |

## Verification
The hardest case to reach is a restart that arrives while a sequence is running. The same sample must then be tracked through delay lines of different lengths at once. The bench sends samples two cycles apart and then on consecutive cycles. It checks that both counters jump back to their start values, and that every delayed strobe keeps one pulse per sample. A reset is also applied while a sample is still inside the output-valid chain. The bench then confirms that no stale pulse comes out afterwards.

// File: rtl/fir_seq_pkg.sv
// Package: shared constants and delay calculations for the folded FIR
// sequencer. Assumes FOLD >= 2.
package fir_seq_pkg;

    // Fixed pipeline latency of the multiply-accumulate chain after accumulation
    localparam int unsigned MAC_PIPE = 5;

    // Delay in clocks from sample strobe to reverse-line capture enable
    function automatic int unsigned cap_delay(input int unsigned fold);
        if (fold >= 4)
            return 3;
        else if (fold == 3)
            return 1;
        else
            return 0;
    endfunction

    // Delay for the last-stage capture: one clock earlier, floored at zero
    function automatic int unsigned last_delay(input int unsigned fold);
        int unsigned d;
        d = cap_delay(fold);
        return (d >= 1) ? d - 1 : 0;
    endfunction

endpackage

// File: rtl/fold_counter.sv
// Module: fold_counter
// Runs a paired up/down address count over FOLD steps after every
// accepted sample. The up count goes 0..FOLD-1 and the down count goes
// FOLD-1..0, stepping on the same edges. A new sample restarts both.
// Assumes FOLD >= 2. Synchronous active-low reset.
module fold_counter #(
    parameter int unsigned FOLD = 4,
    localparam int unsigned AW  = $clog2(FOLD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [AW-1:0] up_addr,
    output logic [AW-1:0] dn_addr
);

    localparam logic [AW-1:0] LAST = AW'(FOLD - 1);

    logic busy;

    // Sequence-active flag: set by a sample, cleared after the last step
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (start)
            busy <= 1'b1;
        else if (busy && up_addr == LAST)
            busy <= 1'b0;
    end

    // Up counter: restart on a sample, step while busy, wrap to 0 at the end
    always_ff @(posedge clk) begin
        if (!rst_n)
            up_addr <= '0;
        else if (start)
            up_addr <= '0;
        else if (busy)
            up_addr <= (up_addr == LAST) ? '0 : up_addr + 1'b1;
    end

    // Down counter: mirror of the up counter, kept in its own register
    always_ff @(posedge clk) begin
        if (!rst_n)
            dn_addr <= LAST;
        else if (start)
            dn_addr <= LAST;
        else if (busy)
            dn_addr <= (dn_addr == '0) ? LAST : dn_addr - 1'b1;
    end

    // R3: the two counts always sum to FOLD-1
    a_r3_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(up_addr) + 32'(dn_addr)) == (FOLD - 1));

    // R2: the up count never passes FOLD-1
    a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(up_addr) <= FOLD - 1);

    // R4: a sample always restarts both counts
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (up_addr == '0 && dn_addr == LAST));

    // R2: an interior step without a new sample adds one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && up_addr != LAST) |=> up_addr == $past(up_addr) + 1'b1);

endmodule

// File: rtl/pulse_delay.sv
// Module: pulse_delay
// Delays a single-bit strobe by DEPTH clocks through a shift register.
// Assumes DEPTH >= 1; the zero-delay case is handled by the parent.
// Synchronous active-low reset clears every stage.
module pulse_delay #(
    parameter int unsigned DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [DEPTH-1:0] stage;

    // Shift the strobe one stage per clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage <= '0;
        else
            stage <= (stage << 1) | DEPTH'(din);
    end

    assign dout = stage[DEPTH-1];

    // R10: a pulse entering is never lost in the first stage
    a_r10_enter: assert property (@(posedge clk) disable iff (!rst_n)
        din |=> stage[0]);

endmodule

// File: rtl/fir_fold_seq.sv
// Module: fir_fold_seq (top)
// Sequencer for a folded, coefficient-symmetric FIR chain. Drives the
// forward/coefficient and reverse read addresses, the forward write
// strobe, the capture strobes (whose delay depends on FOLD), the capture
// source mode flag and the output-valid flag.
// Assumes FOLD >= 2. Synchronous active-low reset.
module fir_fold_seq #(
    parameter int unsigned FOLD      = 4,
    parameter bit          ODD_ORDER = 1'b0,
    localparam int unsigned AW       = $clog2(FOLD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic [AW-1:0] fwd_addr,
    output logic [AW-1:0] rev_addr,
    output logic          shift_we,
    output logic          cap_en,
    output logic          last_cap_en,
    output logic          cap_from_input,
    output logic          out_valid
);

    import fir_seq_pkg::*;

    localparam int unsigned CAP_D  = cap_delay(FOLD);
    localparam int unsigned LAST_D = last_delay(FOLD);
    localparam int unsigned OV_D   = FOLD - 1 + MAC_PIPE;

    // Address generation
    fold_counter #(.FOLD(FOLD)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (in_valid),
        .up_addr (fwd_addr),
        .dn_addr (rev_addr)
    );

    // Forward line write strobe, aligned with address 0
    pulse_delay #(.DEPTH(1)) u_we (
        .clk (clk), .rst_n (rst_n), .din (in_valid), .dout (shift_we)
    );

    // Capture strobe: registered delay or straight pass-through
    generate
        if (CAP_D == 0) begin : g_cap_comb
            assign cap_en = in_valid;
        end else begin : g_cap_reg
            pulse_delay #(.DEPTH(CAP_D)) u_cap (
                .clk (clk), .rst_n (rst_n), .din (in_valid), .dout (cap_en)
            );
        end
    endgenerate

    // Last-stage capture strobe: absent for odd order, one clock early otherwise
    generate
        if (ODD_ORDER) begin : g_last_none
            assign last_cap_en = 1'b0;
        end else if (LAST_D == 0) begin : g_last_comb
            assign last_cap_en = in_valid;
        end else begin : g_last_reg
            pulse_delay #(.DEPTH(LAST_D)) u_last (
                .clk (clk), .rst_n (rst_n), .din (in_valid), .dout (last_cap_en)
            );
        end
    endgenerate

    // Capture source mode: the reverse line's input is used only at FOLD == 2
    assign cap_from_input = (FOLD == 2);

    // Output valid after accumulation plus the fixed MAC pipeline
    pulse_delay #(.DEPTH(OV_D)) u_ov (
        .clk (clk), .rst_n (rst_n), .din (in_valid), .dout (out_valid)
    );

    // R5: each sample writes the forward line on the next cycle
    a_r5_write: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> shift_we);

    // R5: the forward write happens only while the address is 0
    a_r5_addr0: assert property (@(posedge clk) disable iff (!rst_n)
        shift_we |-> fwd_addr == '0);

    // R7: for even order with an earlier slot, last capture leads capture by one
    generate
        if (!ODD_ORDER && CAP_D >= 1) begin : g_chk_lead
            a_r7_lead: assert property (@(posedge clk) disable iff (!rst_n)
                last_cap_en |=> cap_en);
        end
    endgenerate

    // R1: reset leaves every strobe and the valid flag low
    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !shift_we && fwd_addr == '0));

endmodule

// File: tb/sim_fir_fold_seq.sv
// Bench for fir_fold_seq: three variants (FOLD 4 even, FOLD 3 odd,
// FOLD 2 even) run from one stimulus. Expected values come from the requirements.
module sim_fir_fold_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;

    always #10 clk = ~clk;

    logic [1:0] fa0, ra0, fa1, ra1;
    logic [0:0] fa2, ra2;
    logic we[3], cap[3], lst[3], mode[3], ov[3];

    fir_fold_seq #(.FOLD(4), .ODD_ORDER(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fwd_addr(fa0), .rev_addr(ra0),
        .shift_we(we[0]), .cap_en(cap[0]), .last_cap_en(lst[0]),
        .cap_from_input(mode[0]), .out_valid(ov[0]));
    fir_fold_seq #(.FOLD(3), .ODD_ORDER(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fwd_addr(fa1), .rev_addr(ra1),
        .shift_we(we[1]), .cap_en(cap[1]), .last_cap_en(lst[1]),
        .cap_from_input(mode[1]), .out_valid(ov[1]));
    fir_fold_seq #(.FOLD(2), .ODD_ORDER(1'b0)) u2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fwd_addr(fa2), .rev_addr(ra2),
        .shift_we(we[2]), .cap_en(cap[2]), .last_cap_en(lst[2]),
        .cap_from_input(mode[2]), .out_valid(ov[2]));

    // Per-variant expectations from the requirements
    localparam int FOLDS [3] = '{4, 3, 2};
    localparam int CAPD  [3] = '{3, 1, 0};
    localparam int LASTD [3] = '{2, -1, 0};   // -1: odd order, held low
    localparam int OVD   [3] = '{8, 7, 6};

    // Stimulus {in_valid, expected fwd_addr of u0}
    localparam logic [2:0] TBL [26] = '{
        3'b100, 3'b001, 3'b010, 3'b011, 3'b000, 3'b000, 3'b000, 3'b000,
        3'b000, 3'b000, 3'b100, 3'b001, 3'b100, 3'b001, 3'b010, 3'b011,
        3'b100, 3'b100, 3'b001, 3'b010, 3'b011, 3'b000, 3'b000, 3'b000,
        3'b000, 3'b000 };

    int checks = 0;
    int errors = 0;
    logic [15:0] hist = '0;
    int mf [3] = '{0, 0, 0};
    bit mrun [3] = '{0, 0, 0};

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int fwd_of(input int i);
        return (i == 0) ? int'(fa0) : (i == 1) ? int'(fa1) : int'(fa2);
    endfunction

    function automatic int rev_of(input int i);
        return (i == 0) ? int'(ra0) : (i == 1) ? int'(ra1) : int'(ra2);
    endfunction

    // Full check of every variant against the bench model (at negedge)
    task automatic check_all();
        for (int i = 0; i < 3; i++) begin
            chk("R2", "fwd_addr", fwd_of(i), mf[i]);
            chk("R3", "rev_addr", rev_of(i), FOLDS[i] - 1 - mf[i]);
            chk("R5", "shift_we", int'(we[i]), int'(hist[0]));
            chk("R6", "cap_en", int'(cap[i]), int'(CAPD[i] >= 1 ? hist[CAPD[i]-1] : hist[0]));
            if (LASTD[i] < 0)
                chk("R7", "last_cap_en odd", int'(lst[i]), 0);
            else
                chk("R7", "last_cap_en", int'(lst[i]),
                    int'(LASTD[i] >= 1 ? hist[LASTD[i]-1] : hist[0]));
            chk("R9", "out_valid", int'(ov[i]), int'(hist[OVD[i]-1]));
        end
    endtask

    // One clock: apply v, check zero-delay path, step models, check all
    task automatic cycle(input bit v);
        in_valid = v;
        #1;
        chk("R6", "cap_en comb FOLD2", int'(cap[2]), int'(v));
        @(posedge clk);
        hist = {hist[14:0], v};
        for (int i = 0; i < 3; i++) begin
            if (v) begin
                mf[i] = 0; mrun[i] = 1'b1;
            end else if (mrun[i]) begin
                if (mf[i] == FOLDS[i] - 1) begin
                    mf[i] = 0; mrun[i] = 1'b0;
                end else
                    mf[i] = mf[i] + 1;
            end
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic clear_model();
        hist = '0;
        for (int i = 0; i < 3; i++) begin
            mf[i] = 0; mrun[i] = 1'b0;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            chk("R1", "fwd reset", fwd_of(i), 0);
            chk("R1", "rev reset", rev_of(i), FOLDS[i] - 1);
            chk("R1", "we reset", int'(we[i]), 0);
            chk("R1", "ov reset", int'(ov[i]), 0);
        end
        // R8: capture source mode per variant
        chk("R8", "mode FOLD4", int'(mode[0]), 0);
        chk("R8", "mode FOLD3", int'(mode[1]), 0);
        chk("R8", "mode FOLD2", int'(mode[2]), 1);
        rst_n = 1'b1;

        // Table walk: single samples, R4 restarts, R10 back-to-back samples
        for (int k = 0; k < 26; k++) begin
            cycle(TBL[k][2]);
            chk("R2", "fwd table u0", int'(fa0), int'(TBL[k][1:0]));
        end

        // R1: reset while a sample is in flight clears the pipelines
        cycle(1'b1);
        cycle(1'b0);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        for (int i = 0; i < 3; i++) begin
            chk("R1", "fwd mid reset", fwd_of(i), 0);
            chk("R1", "rev mid reset", rev_of(i), FOLDS[i] - 1);
        end
        for (int k = 0; k < 10; k++) begin
            cycle(1'b0);
            chk("R1", "no stale out_valid", int'(ov[0] | ov[1] | ov[2]), 0);
        end

        // R10: a burst of four consecutive samples, then drain
        for (int k = 0; k < 4; k++) cycle(1'b1);
        for (int k = 0; k < 12; k++) cycle(1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule